// File: doc/BRIEF.md
# SPI Master Controller with Word FIFOs

This block is a memory-mapped SPI bus master. Software programs it through four word-wide registers: control, status, data and clock divider. Each register can be written through three aliases. One alias replaces the whole value. One sets the bits that are 1 in the written mask. One clears the bits that are 1 in the written mask. This lets software change single bits without a read-modify-write.

Words of 8, 16 or 32 bits are shifted out most-significant bit first in any of the four clock polarity and phase combinations. The sample point for received data can also be selected. A transmit FIFO and a receive FIFO each hold 16 bytes, so their capacity in words depends on the selected word length. Both fill levels can be read in the status word. When a received word finds the receive FIFO full, the word is dropped and a sticky flag is raised. The block can optionally drive an active-low slave select itself for as long as it has data to send.

Top module: `spim_ctrl`

## Requirements
- R1: The register address is `reg_addr[3:2]` (0 control, 1 status, 2 data, 3 divider) together with `reg_addr[1:0]`, which selects the alias: 0 writes the whole value, 1 ORs the mask in, 2 clears the masked bits, and 3 is ignored. A read returns the current value whatever the alias bits are.
- R2: All 32 control bits are stored and read back. Bits 31 and 23 are kept but change nothing. Control bit 15 enables the block. Bit 5 lets the shift engine run. Bits 11:10 select the word length: 1 gives 16 bits, 2 gives 32 bits, and 0 or 3 give 8 bits.
- R3: Each FIFO holds 16 / (word bytes) words, which is 16, 8 or 4. A push to a full transmit FIFO is dropped. Status bits 20:16 give the transmit level and status bits 28:24 give the receive level.
- R4: Each SCK half period lasts (D + 1) clock cycles, where D is divider bits 8:0. Only those 9 bits are stored. A word produces exactly 2 × (word bits) SCK transitions.
- R5: While no word is shifting, SCK rests at control bit 6 (1 means it idles high).
- R6: MOSI carries the word MSB first. With control bit 8 set, MOSI changes on the active-to-idle SCK edge and is valid on the idle-to-active edge. With bit 8 clear, it changes on the idle-to-active edge and is valid on the active-to-idle edge.
- R7: With control bit 9 clear, MISO is sampled mid-bit, on the edge that comes after the MOSI change edge. With bit 9 set, it is sampled at the end of the bit. A received word lands zero-extended in the receive FIFO.
- R8: A word received while the receive FIFO is full is discarded and sets status bit 6. That flag stays set until software clears it through the status clear alias or a whole-value write of 0.
- R9: With control bit 28 set, `spi_ss_n` is low while the block is enabled and either the transmit FIFO is non-empty or a word is shifting. In every other case it is high.
- R10: While control bit 15 is 0, both FIFOs are empty, pushes are dropped, SCK sits at its idle level and `spi_ss_n` is high. Clearing bit 15 in the middle of a word aborts that word.
- R11: Reading the data register pops the receive FIFO. A read from an empty FIFO returns 0 and leaves the level at 0.
- R12: After reset every register reads 0, SCK and MOSI are low and `spi_ss_n` is high. With bit 15 set and bit 5 clear, pushed words wait in the transmit FIFO and SCK stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO on a data read) |
| reg_addr | input | 4 | Register select [3:2] and alias [1:0] |
| reg_wdata | input | 32 | Write data or mask |
| reg_rdata | output | 32 | Read data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Automatic slave select, active low |

## Verification
The assertions assume that software never changes the polarity, phase or word-length bits while a word is shifting. They also assume that the overflow flag is only changed through the status register. The bench respects this: it reprograms the control word only after the receive level shows that the previous word has finished, and only the disable test touches the control register mid-word. The slave model in the bench shifts MISO on the change edge and samples MOSI on the capture edge, so both the phase setting and the sample point are exercised across every mode, word length and two divider values.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam int unsigned BUS_W = 32;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2,
      REG_BAUD = 2'd3
   } spim_reg_e;

   typedef enum logic [1:0] {
      AL_RAW  = 2'd0,
      AL_SET  = 2'd1,
      AL_CLR  = 2'd2,
      AL_NONE = 2'd3
   } spim_alias_e;

   // control word bit positions (software visible)
   localparam int CB_MST      = 5;
   localparam int CB_CPOL     = 6;
   localparam int CB_LATE_CHG = 8;
   localparam int CB_LATE_SMP = 9;
   localparam int CB_WSEL     = 10;
   localparam int CB_ON       = 15;
   localparam int CB_AUTO_SS  = 28;

   // status word bit positions
   localparam int SB_OVF = 6;
   localparam int SB_TXL = 16;
   localparam int SB_RXL = 24;

   function automatic logic [BUS_W-1:0] apply_alias(input logic [BUS_W-1:0] cur,
                                                    input logic [BUS_W-1:0] msk,
                                                    input spim_alias_e al);
      case (al)
         AL_RAW:  return msk;
         AL_SET:  return cur | msk;
         AL_CLR:  return cur & ~msk;
         default: return cur;
      endcase
   endfunction

   function automatic logic [5:0] word_bits(input logic [1:0] wsel);
      case (wsel)
         2'd1:    return 6'd16;
         2'd2:    return 6'd32;
         default: return 6'd8;
      endcase
   endfunction

   function automatic logic [BUS_W-1:0] word_mask(input logic [1:0] wsel);
      case (wsel)
         2'd1:    return 32'h0000_FFFF;
         2'd2:    return 32'hFFFF_FFFF;
         default: return 32'h0000_00FF;
      endcase
   endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [LVL_W-1:0]  cap,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [LVL_W-1:0]  level,
   output logic              full
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              do_push, do_pop;

   assign full    = (level >= cap);
   assign do_push = push && !full;
   assign do_pop  = pop && (level != '0);
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
         if (do_push && !flush && wr_ptr == PTR_W'(i)) mem[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
   parameter int unsigned BAUD_W = 9,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              on,
   input  logic              run,
   input  logic              cpol,
   input  logic              late_chg,
   input  logic              late_smp,
   input  logic [1:0]        wsel,
   input  logic [BAUD_W-1:0] baud,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_word,
   output logic              tx_take,
   output logic              rx_done,
   output logic [DATA_W-1:0] rx_word,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              busy
);
   import spim_pkg::*;

   if (DATA_W != BUS_W) begin : g_bad_width
      $error("spim_engine: DATA_W must equal the package bus width");
   end

   logic              busy_q, half_q;
   logic [BAUD_W-1:0] div_q;
   logic [CNT_W-1:0]  bit_q;
   logic [DATA_W-1:0] txsh_q, rxsh_q, rx_in;
   logic [5:0]        nbits;
   logic              tick, active;

   assign nbits   = word_bits(wsel);
   assign tick    = busy_q && (div_q == baud);
   assign tx_take = on && run && !busy_q && tx_valid;
   assign rx_in   = {rxsh_q[DATA_W-2:0], miso};
   assign rx_done = on && tick && half_q && (bit_q == '0);
   assign rx_word = (late_smp ? rx_in : rxsh_q) & word_mask(wsel);
   assign active  = on && busy_q;
   assign sck     = cpol ^ (active && (late_chg ? half_q : !half_q));
   assign mosi    = active && txsh_q[DATA_W-1];
   assign busy    = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         half_q <= 1'b0;
         div_q  <= '0;
         bit_q  <= '0;
         txsh_q <= '0;
         rxsh_q <= '0;
      end else if (!on) begin
         busy_q <= 1'b0;
         half_q <= 1'b0;
         div_q  <= '0;
      end else if (tx_take) begin
         busy_q <= 1'b1;
         half_q <= 1'b0;
         div_q  <= '0;
         bit_q  <= CNT_W'(nbits - 6'd1);
         txsh_q <= tx_word << (DATA_W - nbits);
         rxsh_q <= '0;
      end else if (busy_q) begin
         if (tick) begin
            div_q  <= '0;
            half_q <= !half_q;
            if (!half_q) begin
               if (!late_smp) rxsh_q <= rx_in;
            end else begin
               if (late_smp) rxsh_q <= rx_in;
               txsh_q <= txsh_q << 1;
               if (bit_q == '0) busy_q <= 1'b0;
               else             bit_q  <= bit_q - 1'b1;
            end
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
   parameter int unsigned FIFO_BYTES = 16,
   parameter int unsigned BAUD_W     = 9,
   parameter int unsigned LVL_W      = $clog2(FIFO_BYTES + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        spi_sck,
   output logic        spi_mosi,
   input  logic        spi_miso,
   output logic        spi_ss_n
);
   import spim_pkg::*;

   if (FIFO_BYTES < 4 || FIFO_BYTES > 16 || (FIFO_BYTES & (FIFO_BYTES - 1)) != 0) begin : g_bad_fifo
      $error("spim_ctrl: FIFO_BYTES must be a power of two from 4 to 16");
   end
   if (BAUD_W < 1 || BAUD_W > 16) begin : g_bad_baud
      $error("spim_ctrl: BAUD_W out of range");
   end

   spim_reg_e     rsel;
   spim_alias_e   asel;
   logic [31:0]   ctrl_q;
   logic [BAUD_W-1:0] baud_q;
   logic          ovf_q;
   logic [31:0]   baud_next, stat_next, stat_cur;
   logic          ctrl_on, run, cpol, late_chg, late_smp, auto_ss, stat_wr;
   logic [1:0]    wsel;
   logic [LVL_W-1:0] cap, tx_level, rx_level;
   logic          tx_full, rx_full, tx_take, rx_done, eng_busy, ovf_evt;
   logic [31:0]   tx_head, rx_head, rx_word;

   assign rsel     = spim_reg_e'(reg_addr[3:2]);
   assign asel     = spim_alias_e'(reg_addr[1:0]);
   assign ctrl_on  = ctrl_q[CB_ON];
   assign run      = ctrl_q[CB_MST];
   assign cpol     = ctrl_q[CB_CPOL];
   assign late_chg = ctrl_q[CB_LATE_CHG];
   assign late_smp = ctrl_q[CB_LATE_SMP];
   assign auto_ss  = ctrl_q[CB_AUTO_SS];
   assign wsel     = ctrl_q[CB_WSEL +: 2];
   assign stat_wr  = reg_wr && (rsel == REG_STAT);

   always_comb begin
      case (wsel)
         2'd1:    cap = LVL_W'(FIFO_BYTES / 2);
         2'd2:    cap = LVL_W'(FIFO_BYTES / 4);
         default: cap = LVL_W'(FIFO_BYTES);
      endcase
   end

   always_comb begin
      stat_cur = '0;
      stat_cur[SB_OVF]          = ovf_q;
      stat_cur[SB_TXL +: LVL_W] = tx_level;
      stat_cur[SB_RXL +: LVL_W] = rx_level;
   end

   assign baud_next = apply_alias({{(32 - BAUD_W){1'b0}}, baud_q}, reg_wdata, asel);
   assign stat_next = apply_alias(stat_cur, reg_wdata, asel);
   assign ovf_evt   = rx_done && rx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         baud_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (reg_wr && rsel == REG_CTRL) ctrl_q <= apply_alias(ctrl_q, reg_wdata, asel);
         if (reg_wr && rsel == REG_BAUD) baud_q <= baud_next[BAUD_W-1:0];
         if (ovf_evt)      ovf_q <= 1'b1;
         else if (stat_wr) ovf_q <= stat_next[SB_OVF];
      end
   end

   spim_fifo #(.DATA_W(32), .DEPTH(FIFO_BYTES), .LVL_W(LVL_W)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!ctrl_on),
      .cap   (cap),
      .push  (reg_wr && rsel == REG_DATA && asel == AL_RAW),
      .wdata (reg_wdata),
      .pop   (tx_take),
      .rdata (tx_head),
      .level (tx_level),
      .full  (tx_full)
   );

   spim_fifo #(.DATA_W(32), .DEPTH(FIFO_BYTES), .LVL_W(LVL_W)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!ctrl_on),
      .cap   (cap),
      .push  (rx_done),
      .wdata (rx_word),
      .pop   (reg_rd && rsel == REG_DATA),
      .rdata (rx_head),
      .level (rx_level),
      .full  (rx_full)
   );

   spim_engine #(.BAUD_W(BAUD_W), .DATA_W(32)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .on       (ctrl_on),
      .run      (run),
      .cpol     (cpol),
      .late_chg (late_chg),
      .late_smp (late_smp),
      .wsel     (wsel),
      .baud     (baud_q),
      .tx_valid (tx_level != '0),
      .tx_word  (tx_head),
      .tx_take  (tx_take),
      .rx_done  (rx_done),
      .rx_word  (rx_word),
      .miso     (spi_miso),
      .sck      (spi_sck),
      .mosi     (spi_mosi),
      .busy     (eng_busy)
   );

   always_comb begin
      case (rsel)
         REG_CTRL: reg_rdata = ctrl_q;
         REG_STAT: reg_rdata = stat_cur;
         REG_DATA: reg_rdata = (rx_level != '0) ? rx_head : 32'h0;
         default:  reg_rdata = {{(32 - BAUD_W){1'b0}}, baud_q};
      endcase
   end

   assign spi_ss_n = !(ctrl_on && auto_ss && ((tx_level != '0) || eng_busy));

endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
   parameter int unsigned FIFO_BYTES = 16,
   parameter int unsigned LVL_W      = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_on,
   input logic             auto_ss,
   input logic             cpol,
   input logic             busy,
   input logic             sck,
   input logic             ss_n,
   input logic [LVL_W-1:0] tx_level,
   input logic [LVL_W-1:0] rx_level,
   input logic             ovf,
   input logic             stat_wr
);
   // R5: idle clock level follows the polarity bit
   p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == cpol));

   // R9: disabled block never selects a slave
   p_ss_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_on |-> ss_n);

   // R9: a word in flight keeps automatic select low
   p_ss_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctrl_on && auto_ss) |-> !ss_n);

   // R10: disable empties both queues by the next cycle
   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_on |=> (tx_level == '0 && rx_level == '0));

   // R8: overflow flag only drops through a status write
   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !stat_wr) |=> ovf);

   // R3: levels never exceed the storage
   p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= LVL_W'(FIFO_BYTES)) && (rx_level <= LVL_W'(FIFO_BYTES)));
endmodule

bind spim_ctrl spim_ctrl_chk #(.FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_on  (ctrl_on),
   .auto_ss  (auto_ss),
   .cpol     (cpol),
   .busy     (eng_busy),
   .sck      (spi_sck),
   .ss_n     (spi_ss_n),
   .tx_level (tx_level),
   .rx_level (rx_level),
   .ovf      (ovf_q),
   .stat_wr  (stat_wr)
);

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        spi_sck, spi_mosi, spi_miso, spi_ss_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   spim_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
   );

   // slave model
   logic        mon_cpol = 1'b0, mon_cke = 1'b0;
   logic [32:0] s_sreg = '0;
   logic [31:0] cap_word = '0;
   int          tog = 0;
   time         t1 = 0, t2 = 0;
   bit          ss_low = 1'b0;

   assign spi_miso = s_sreg[32];

   always @(spi_sck) begin
      if (rst_n) begin
         tog++;
         if (tog == 1) t1 = $time;
         if (tog == 2) t2 = $time;
         if ((spi_sck != mon_cpol) != mon_cke) s_sreg = {s_sreg[31:0], 1'b0};
         else cap_word = {cap_word[30:0], spi_mosi};
      end
   end

   always @(negedge clk) if (rst_n && !spi_ss_n) ss_low = 1'b1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] r, input logic [1:0] al, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = {r, al}; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] r, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = {r, 2'b00};
      #5 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_word(input bit on, input bit mst, input bit pol,
                                             input bit cke, input bit smp, input logic [1:0] ws,
                                             input bit ss);
      return (32'(on) << 15) | (32'(mst) << 5) | (32'(pol) << 6) | (32'(cke) << 8) |
             (32'(smp) << 9) | (32'(ws) << 10) | (32'(ss) << 28);
   endfunction

   function automatic int nbits(input logic [1:0] ws);
      return (ws == 2'd1) ? 16 : (ws == 2'd2) ? 32 : 8;
   endfunction

   function automatic logic [31:0] wmask(input logic [1:0] ws);
      return (ws == 2'd2) ? 32'hFFFF_FFFF : ((32'h1 << nbits(ws)) - 1);
   endfunction

   task automatic wait_rx(input int want);
      logic [31:0] s;
      for (int k = 0; k < 3000; k++) begin
         rd(2'd1, s);
         if (int'(s[28:24]) >= want) break;
      end
   endtask

   task automatic xfer(input bit pol, input bit cke, input bit smp, input logic [1:0] ws,
                       input int bd, input bit ss, input logic [31:0] pat, input logic [31:0] txw);
      logic [31:0] d, pla;
      int n;
      n = nbits(ws);
      wr(2'd3, 2'd0, 32'(bd));
      wr(2'd0, 2'd0, ctrl_word(1, 1, pol, cke, smp, ws, ss));
      @(negedge clk);
      mon_cpol = pol; mon_cke = cke;
      pla = (pat & wmask(ws)) << (32 - n);
      s_sreg = cke ? {pla, 1'b0} : {1'b0, pla};
      cap_word = '0; tog = 0; ss_low = 1'b0;
      wr(2'd2, 2'd0, txw);
      wait_rx(1);
      chk(spi_sck == pol, "R5 idle sck", 32'(spi_sck), 32'(pol));
      chk(spi_ss_n == 1'b1, "R9 ss released after word", 32'(spi_ss_n), 32'd1);
      chk(ss_low == ss, "R9 ss during word", 32'(ss_low), 32'(ss));
      chk(tog == 2 * n, "R4 edge count", 32'(tog), 32'(2 * n));
      chk((t2 - t1) == time'((bd + 1) * 20), "R4 half period", 32'(t2 - t1), 32'((bd + 1) * 20));
      chk(cap_word == (txw & wmask(ws)), "R6 mosi word", cap_word, txw & wmask(ws));
      rd(2'd2, d);
      chk(d == (pat & wmask(ws)), "R7 received word", d, pat & wmask(ws));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int idx;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      rd(2'd0, d); chk(d == 0, "R12 ctrl reset", d, 0);
      rd(2'd1, d); chk(d == 0, "R12 status reset", d, 0);
      rd(2'd3, d); chk(d == 0, "R12 divider reset", d, 0);
      chk(spi_ss_n && !spi_sck && !spi_mosi, "R12 pins reset",
          {29'd0, spi_ss_n, spi_sck, spi_mosi}, 32'd4);

      // R1 / R2 aliases and plain storage
      wr(2'd0, 2'd0, 32'h8080_0000);
      rd(2'd0, d); chk(d == 32'h8080_0000, "R2 stored unused bits", d, 32'h8080_0000);
      wr(2'd0, 2'd1, 32'h0000_0040);
      rd(2'd0, d); chk(d == 32'h8080_0040, "R1 set alias", d, 32'h8080_0040);
      chk(spi_sck == 1'b1, "R5 idle high", 32'(spi_sck), 1);
      wr(2'd0, 2'd2, 32'h8000_0000);
      rd(2'd0, d); chk(d == 32'h0080_0040, "R1 clear alias", d, 32'h0080_0040);
      wr(2'd0, 2'd3, 32'hFFFF_FFFF);
      rd(2'd0, d); chk(d == 32'h0080_0040, "R1 alias 3 ignored", d, 32'h0080_0040);
      wr(2'd3, 2'd0, 32'hFFFF_FFFF);
      rd(2'd3, d); chk(d == 32'h1FF, "R4 divider 9 bits", d, 32'h1FF);
      wr(2'd3, 2'd2, 32'h0000_00F0);
      rd(2'd3, d); chk(d == 32'h10F, "R1 divider clear alias", d, 32'h10F);

      // R10 push while off is dropped
      wr(2'd0, 2'd0, 32'h0);
      wr(2'd2, 2'd0, 32'h55);
      rd(2'd1, d); chk(d[20:16] == 0, "R10 push while off", 32'(d[20:16]), 0);

      // R3 capacity per width, R10 flush
      for (int w = 0; w < 3; w++) begin
         wr(2'd0, 2'd0, ctrl_word(1, 0, 0, 0, 0, 2'(w), 0));
         for (int k = 0; k < 20; k++) wr(2'd2, 2'd0, 32'(k));
         rd(2'd1, d);
         chk(int'(d[20:16]) == (16 >> w), "R3 tx capacity", 32'(d[20:16]), 32'(16 >> w));
         wr(2'd0, 2'd2, 32'h0000_8000);
         rd(2'd1, d); chk(d == 0, "R10 flush on disable", d, 0);
      end

      // R11 pop from empty
      wr(2'd0, 2'd0, ctrl_word(1, 0, 0, 0, 0, 2'd0, 0));
      rd(2'd2, d); chk(d == 0, "R11 empty read value", d, 0);
      rd(2'd1, d); chk(d[28:24] == 0, "R11 empty pop level", 32'(d[28:24]), 0);

      // R12 engine held without master bit
      tog = 0;
      wr(2'd2, 2'd0, 32'hA5);
      repeat (100) @(negedge clk);
      rd(2'd1, d);
      chk(d[20:16] == 1 && tog == 0, "R12 held without master", {d[20:16], 27'(tog)}, 32'h0800_0000);
      wr(2'd0, 2'd0, 32'h0);

      // R4..R9 sweep over every mode, width and two dividers
      idx = 0;
      for (int m = 0; m < 8; m++) begin
         for (int w = 0; w < 3; w++) begin
            for (int b = 0; b < 2; b++) begin
               xfer(m[0], m[1], m[2], 2'(w), b * 2, (idx % 3) != 2,
                    32'hC3A5_1E69 ^ (32'(idx) * 32'h0101_0107),
                    32'h5A3C_96E1 + (32'(idx) * 32'h0011_2233));
               idx++;
            end
         end
      end

      // R8 overflow with 4-word capacity
      wr(2'd0, 2'd0, 32'h0);
      wr(2'd0, 2'd0, ctrl_word(1, 1, 0, 1, 1, 2'd2, 0));
      for (int k = 0; k < 4; k++) wr(2'd2, 2'd0, 32'(k));
      wait_rx(4);
      rd(2'd1, d); chk(d[6] == 0, "R8 no flag at capacity", 32'(d[6]), 0);
      wr(2'd2, 2'd0, 32'h77);
      repeat (200) @(negedge clk);
      rd(2'd1, d);
      chk(d[6] == 1 && d[28:24] == 4, "R8 overflow flag and level", d, 32'h0400_0040);
      wr(2'd1, 2'd1, 32'h0);
      rd(2'd1, d); chk(d[6] == 1, "R8 flag sticky", 32'(d[6]), 1);
      wr(2'd1, 2'd2, 32'h40);
      rd(2'd1, d); chk(d[6] == 0, "R8 clear alias", 32'(d[6]), 0);

      // R10 abort mid-word
      wr(2'd3, 2'd0, 32'd7);
      wr(2'd0, 2'd0, ctrl_word(1, 1, 1, 0, 0, 2'd2, 1));
      wr(2'd2, 2'd0, 32'hDEAD_BEEF);
      repeat (40) @(negedge clk);
      chk(spi_ss_n == 0, "R9 ss low mid word", 32'(spi_ss_n), 0);
      wr(2'd0, 2'd2, 32'h0000_8000);
      chk(spi_sck == 1 && spi_ss_n == 1, "R10 abort pins", {30'd0, spi_sck, spi_ss_n}, 32'd3);
      rd(2'd1, d); chk(d == 0, "R10 abort levels", d, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule